// File: doc/BRIEF.md
# Write-Protect Status Register Controller

This unit keeps the 8-bit status register of a serial memory and decides, for every write the serial front-end decodes, whether that write may proceed. The front-end hands it single-cycle requests: set the write-enable latch, clear it, write the status register with a data byte, or write the array at an address. The unit also samples an external write-protect pin.

An accepted write starts a self-timed busy cycle. A down-counter of programmable length stands in for the nonvolatile programming time. While that cycle runs, the write-in-progress flag reads 1 and the register can still be read. Array writes are granted or dropped by comparing the address against the region named by the two block-protect bits. A status-write-disable bit, together with the protect pin, can freeze those bits. The register bits are held in flip-flops. When an array write is accepted, the unit emits a one-cycle grant pulse for the storage logic.

Top module: `protStatusUnit`

## Requirements
- R1: The status output carries SRWD at bit 7, zeros at bits 6..4, BP1 at bit 3, BP0 at bit 2, WEL at bit 1 and WIP at bit 0. Every bit is 0 after reset.
- R2: While idle (WIP=0), a write-enable request sets WEL and a write-disable request clears it, one clock after the request is sampled.
- R3: A status write or array write that arrives while WEL=0 is ignored: no busy cycle starts and no grant is issued.
- R4: An accepted array write raises `arrWrGrant` for exactly one cycle and sets WIP in the cycle after the request. WIP stays 1 for BUSY_CYCLES cycles. When it drops, WEL drops in the same cycle.
- R5: Array addresses are locked according to BP1:BP0. With 00, nothing is locked. With 01, addresses whose top two bits are 11 are locked (0x600..0x7FF at 11 bits). With 10, addresses whose top bit is 1 are locked (0x400..0x7FF). With 11, every address is locked. A write to a locked address is dropped with no grant and no busy cycle, and WEL keeps its value.
- R6: An accepted status write takes only data bits 7, 3 and 2 into SRWD, BP1 and BP0 and ignores the other data bits. The old values stay visible until the busy cycle ends. The new values appear in the same cycle that WIP and WEL fall to 0.
- R7: While SRWD=1 and `wpPin`=0, a status write is rejected: no busy cycle starts, the register is unchanged and WEL stays 1. If `wpPin`=1 or SRWD=0, the status write is accepted when WEL is set.
- R8: While WIP=1, write-enable, write-disable, status-write and array-write requests are all ignored. The status output stays readable throughout the busy cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqWren | input | 1 | Set write-enable latch request (one cycle) |
| reqWrdi | input | 1 | Clear write-enable latch request (one cycle) |
| reqStatWr | input | 1 | Status register write request (one cycle) |
| statData | input | 8 | Data byte for a status write |
| reqArrWr | input | 1 | Array write request (one cycle) |
| arrAddr | input | ADDR_W | Byte address of the array write |
| wpPin | input | 1 | Write-protect pin level (low protects) |
| statusOut | output | 8 | Status register contents |
| arrWrGrant | output | 1 | One-cycle pulse: array write accepted |

## Verification
Each request's effect is due exactly one clock after the edge that samples it: WEL changes, WIP rises and the grant pulse appears then. Completion effects (WIP and WEL falling, new protection bits) are due BUSY_CYCLES edges after WIP rose. A behavioural model in the bench advances on the same edges from the same inputs and is compared with both outputs at every falling edge. Directed checks read the outputs one time step after the sampling edge, and again at the last busy cycle and the first idle cycle, so that the exact busy length is confirmed.

// File: rtl/protStatusPkg.sv
package protStatusPkg;
  // Strobes from control to the status datapath, one cycle each.
  typedef struct packed {
    logic welSet;     // latch write enable
    logic welClr;     // drop write enable
    logic startStat;  // begin a status-write busy cycle
    logic startArr;   // begin an array-write busy cycle
    logic finish;     // busy cycle ends this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/statusPath.sv
module statusPath
  import protStatusPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        statData,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        statusOut,
  output logic              addrLocked,
  output logic              welQ,
  output logic              wipQ,
  output logic              srwdQ
);
  localparam int TOP = ADDR_W - 1;

  logic       srwd;
  logic [1:0] bp;
  logic       wel;
  logic       wip;
  logic       pendSrwd;
  logic [1:0] pendBp;
  logic       pendIsStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srwd       <= 1'b0;
      bp         <= 2'b00;
      wel        <= 1'b0;
      wip        <= 1'b0;
      pendSrwd   <= 1'b0;
      pendBp     <= 2'b00;
      pendIsStat <= 1'b0;
    end else begin
      if (strobe.startStat) begin
        wip        <= 1'b1;
        pendSrwd   <= statData[7];
        pendBp     <= statData[3:2];
        pendIsStat <= 1'b1;
      end else if (strobe.startArr) begin
        wip        <= 1'b1;
        pendIsStat <= 1'b0;
      end else if (strobe.finish) begin
        wip <= 1'b0;
        if (pendIsStat) begin
          srwd <= pendSrwd;
          bp   <= pendBp;
        end
      end
      if (strobe.finish)      wel <= 1'b0;
      else if (strobe.welSet) wel <= 1'b1;
      else if (strobe.welClr) wel <= 1'b0;
    end
  end

  always_comb begin
    unique case (bp)
      2'b00:   addrLocked = 1'b0;
      2'b01:   addrLocked = &arrAddr[TOP -: 2];
      2'b10:   addrLocked = arrAddr[TOP];
      default: addrLocked = 1'b1;
    endcase
  end

  assign statusOut = {srwd, 3'b000, bp, wel, wip};
  assign welQ  = wel;
  assign wipQ  = wip;
  assign srwdQ = srwd;

  AST_WEL_BEFORE_WIP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel)); // R3
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R4
  AST_PROT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wip && !strobe.finish) |=> $stable({srwd, bp})); // R6
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (wip && !strobe.finish) |=> (wip && $stable(wel))); // R8
endmodule

// File: rtl/statusCtrl.sv
module statusCtrl
  import protStatusPkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqWren,
  input  logic        reqWrdi,
  input  logic        reqStatWr,
  input  logic        reqArrWr,
  input  logic        wpPin,
  input  logic        welQ,
  input  logic        wipQ,
  input  logic        srwdQ,
  input  logic        addrLocked,
  output ctrlStrobe_t strobe,
  output logic        arrWrGrant
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             statOk;
  logic             arrOk;

  assign statOk = welQ && !(srwdQ && !wpPin);
  assign arrOk  = welQ && !addrLocked;

  always_comb begin
    strobe        = '0;
    strobe.finish = wipQ && (cnt == CNT_LAST);
    if (!wipQ) begin
      if (reqWren)                 strobe.welSet    = 1'b1;
      else if (reqWrdi)            strobe.welClr    = 1'b1;
      else if (reqStatWr && statOk) strobe.startStat = 1'b1;
      else if (reqArrWr && arrOk)  strobe.startArr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      arrWrGrant <= 1'b0;
    end else begin
      arrWrGrant <= strobe.startArr;
      if (strobe.startStat || strobe.startArr) cnt <= CNT_LOAD;
      else if (strobe.finish)                  cnt <= '0;
      else if (wipQ)                           cnt <= cnt - CNT_LAST;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LOAD); // R4
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    arrWrGrant |=> !arrWrGrant); // R4
  AST_LOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (reqArrWr && addrLocked) |=> !arrWrGrant); // R5
  AST_HW_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    (!wipQ && reqStatWr && !reqWren && !reqWrdi && srwdQ && !wpPin) |=> !wipQ); // R7
endmodule

// File: rtl/protStatusUnit.sv
module protStatusUnit
  import protStatusPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWren,
  input  logic              reqWrdi,
  input  logic              reqStatWr,
  input  logic [7:0]        statData,
  input  logic              reqArrWr,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              wpPin,
  output logic [7:0]        statusOut,
  output logic              arrWrGrant
);
  ctrlStrobe_t strobe;
  logic welQ, wipQ, srwdQ, addrLocked;

  statusCtrl #(.BUSY_CYCLES(BUSY_CYCLES)) i_statusCtrl (
    .clk(clk), .rstN(rstN),
    .reqWren(reqWren), .reqWrdi(reqWrdi),
    .reqStatWr(reqStatWr), .reqArrWr(reqArrWr),
    .wpPin(wpPin), .welQ(welQ), .wipQ(wipQ), .srwdQ(srwdQ),
    .addrLocked(addrLocked), .strobe(strobe), .arrWrGrant(arrWrGrant)
  );

  statusPath #(.ADDR_W(ADDR_W)) i_statusPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .statData(statData), .arrAddr(arrAddr),
    .statusOut(statusOut), .addrLocked(addrLocked),
    .welQ(welQ), .wipQ(wipQ), .srwdQ(srwdQ)
  );

  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (statusOut == 8'h00)); // R1
endmodule

// File: tb/test_protStatusUnit.sv
module test_protStatusUnit;
  localparam int PERIOD = 10;
  localparam int AW     = 11;
  localparam int BUSY   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqWren = 1'b0, reqWrdi = 1'b0, reqStatWr = 1'b0, reqArrWr = 1'b0;
  logic [7:0]    statData = 8'h00;
  logic [AW-1:0] arrAddr = '0;
  logic          wpPin = 1'b1;
  logic [7:0]    statusOut;
  logic          arrWrGrant;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  protStatusUnit #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) i_protStatusUnit (
    .clk(clk), .rstN(rstN), .reqWren(reqWren), .reqWrdi(reqWrdi),
    .reqStatWr(reqStatWr), .statData(statData), .reqArrWr(reqArrWr),
    .arrAddr(arrAddr), .wpPin(wpPin), .statusOut(statusOut),
    .arrWrGrant(arrWrGrant)
  );

  always #(PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int mSrwd = 0, mBp = 0, mWel = 0, mWip = 0, mLeft = 0, mGrant = 0;
  int mPendKind = 0, mPendByte = 0;

  function automatic bit lockedAt(int bpv, int addr);
    int limit;
    limit = (bpv == 0) ? 2048 : (bpv == 1) ? 1536 : (bpv == 2) ? 1024 : 0;
    return addr >= limit;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSrwd = 0; mBp = 0; mWel = 0; mWip = 0; mLeft = 0; mGrant = 0; mPendKind = 0;
    end else begin
      mGrant = 0;
      if (mWip == 1) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          mWip = 0; mWel = 0;
          if (mPendKind == 1) begin
            mSrwd = (mPendByte >> 7) & 1;
            mBp   = (mPendByte >> 2) & 3;
          end
        end
      end else if (reqWren) mWel = 1;
      else if (reqWrdi) mWel = 0;
      else if (reqStatWr && mWel == 1 && !(mSrwd == 1 && wpPin == 0)) begin
        mWip = 1; mLeft = BUSY; mPendKind = 1; mPendByte = statData;
      end else if (reqArrWr && mWel == 1 && !lockedAt(mBp, int'(arrAddr))) begin
        mWip = 1; mLeft = BUSY; mPendKind = 2; mGrant = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 R4 R5 R6 R8 model status", statusOut,
          (mSrwd << 7) | (mBp << 2) | (mWel << 1) | mWip);
      chk("R4 R5 model grant", arrWrGrant, mGrant);
    end
  end

  // Pulse one request; returns one step after the sampling edge.
  task automatic req(int kind, int data);
    @(posedge clk); #1;
    case (kind)
      0: reqWren = 1'b1;
      1: reqWrdi = 1'b1;
      2: begin reqStatWr = 1'b1; statData = data[7:0]; end
      default: begin reqArrWr = 1'b1; arrAddr = data[AW-1:0]; end
    endcase
    @(posedge clk); #1;
    reqWren = 0; reqWrdi = 0; reqStatWr = 0; reqArrWr = 0;
  endtask

  task automatic settle();
    repeat (BUSY) @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 reset status", statusOut, 8'h00);

    // R3: no WEL
    req(3, 'h010);
    chk("R3 array write without WEL grant", arrWrGrant, 0);
    chk("R3 array write without WEL status", statusOut, 8'h00);
    req(2, 'h8C);
    chk("R3 status write without WEL", statusOut, 8'h00);

    // R2
    req(0, 0);
    chk("R2 wren sets WEL", statusOut, 8'h02);
    req(1, 0);
    chk("R2 wrdi clears WEL", statusOut, 8'h00);

    // R4: accepted array write and busy length
    req(0, 0);
    req(3, 'h123);
    chk("R4 grant pulse", arrWrGrant, 1);
    chk("R4 WIP set", statusOut, 8'h03);
    repeat (BUSY - 1) @(posedge clk);
    #1;
    chk("R4 grant single cycle", arrWrGrant, 0);
    chk("R4 WIP at last busy cycle", statusOut, 8'h03);
    @(posedge clk); #1;
    chk("R4 WIP and WEL cleared", statusOut, 8'h00);

    // R6: only bits 7,3,2 taken, old values kept while busy; R8 while busy
    req(0, 0);
    req(2, 'hF7);
    chk("R6 old protection kept while busy", statusOut, 8'h03);
    req(1, 0);
    chk("R8 wrdi ignored while busy", statusOut, 8'h03);
    req(3, 'h000);
    chk("R8 array write ignored while busy", arrWrGrant, 0);
    settle();
    chk("R6 new bits at completion", statusOut, 8'h84);

    // R5: BP=01
    req(0, 0);
    req(3, 'h5FF);
    chk("R5 bp01 below quarter granted", arrWrGrant, 1);
    settle();
    req(0, 0);
    req(3, 'h600);
    chk("R5 bp01 0x600 blocked", arrWrGrant, 0);
    chk("R5 bp01 blocked keeps WEL", statusOut, 8'h86);
    req(3, 'h7FF);
    chk("R5 bp01 0x7FF blocked", arrWrGrant, 0);

    // BP=10
    req(2, 'h88);
    settle();
    chk("R6 bp10 applied", statusOut, 8'h88);
    req(0, 0);
    req(3, 'h400);
    chk("R5 bp10 0x400 blocked", arrWrGrant, 0);
    req(3, 'h3FF);
    chk("R5 bp10 0x3FF granted", arrWrGrant, 1);
    settle();

    // BP=11 and hardware protection
    req(0, 0);
    req(2, 'h8C);
    settle();
    chk("R6 bp11 applied", statusOut, 8'h8C);
    req(0, 0);
    req(3, 'h000);
    chk("R5 bp11 0x000 blocked", arrWrGrant, 0);
    chk("R5 bp11 WEL kept", statusOut, 8'h8E);

    wpPin = 1'b0;
    req(2, 'h00);
    chk("R7 status write rejected with pin low", statusOut, 8'h8E);
    repeat (2) @(posedge clk); #1;
    chk("R7 still unchanged", statusOut, 8'h8E);
    wpPin = 1'b1;
    req(2, 'h00);
    chk("R7 accepted with pin high", statusOut, 8'h8F);
    settle();
    chk("R7 cleared protection", statusOut, 8'h00);

    // BP=00 top address
    req(0, 0);
    req(3, 'h7FF);
    chk("R5 bp00 0x7FF granted", arrWrGrant, 1);
    req(0, 0);
    chk("R8 wren ignored while busy", statusOut, 8'h03);
    settle();
    chk("R4 final idle", statusOut, 8'h00);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule